// File: doc/BRIEF.md
# Selective Wake Configuration Register Bank

This block is the byte-addressed register bank that sits beside a wake-up controller. That controller filters frames from a CAN bus and wakes the system only on a chosen frame. The bank holds several groups of settings. One is the wake enable. The frame filter settings are the identifier, the identifier mask, the length code and eight payload bytes. The bus settings are the nominal rate code, the flexible-data-rate handling and the error threshold. The bank also holds a flag with which software declares that the filter setup is complete. Every setting is driven out in parallel to the frame matcher and the error counter.

The status side takes inputs from those neighbours: a frame-done strobe with two decode-sync results, an overflow pulse from the error counter, and that counter's current value. From the stored state it derives a combined wake-error status. Each of the two flags can raise a registered interrupt line, and each has its own enable. Software makes its setup protected by design. Any write into the filter or threshold space withdraws the completion flag. While the wake-error status is high, the wake enable cannot be turned on.

The host port is a plain strobe interface: address, write data, write strobe, read strobe and registered read data.

Top module: `swk_regbank`

## Requirements
- R1: After a synchronous reset the registers take these values: wake enable 0, completion flag 0, rate code 3'b101, threshold 8'h1F, overflow interrupt enable (56h bit 3) 1, error interrupt enable (58h bit 6) 0. All other registers, the flags and irq_o are 0.
- R2: A write to 10h loads bit 7 into the wake enable. A 1 is refused (the enable stays 0) when the enable is 0 and the wake-error status is 1. Writing 0 always clears the enable.
- R3: A write to 47h loads bit 7 into the completion flag. A write to any address from 30h to 44h inclusive, or to 46h, clears the flag on that clock.
- R4: The wake-error status is 1 exactly when the wake enable is set and the completion flag is clear, or when the overflow flag is set. It appears on werr_o and reads back as bit 6 of 53h.
- R5: The overflow flag is set by an ovf_set_i pulse. Writing a 1 to bit 3 of 51h clears it, and a set on the same clock wins. The flag reads back as bit 3 of 51h.
- R6: On the clock after the flags and enables settle, irq_o equals (overflow AND enable at 56h bit 3) OR (wake-error AND enable at 58h bit 6).
- R7: The rate code occupies bits 6:4 of 44h. A write carrying code 3'b100 or 3'b110 leaves the stored code unchanged, while the other fields of 44h (bit 7 and bits 3:2) still update.
- R8: On frm_done_i, bit 6 of 47h loads frm_sync_fd_i and bit 5 loads frm_sync_i. A read of 47h clears both bits afterwards, unless a frame-done arrives on the same clock, in which case the new values are kept.
- R9: Reserved bits read 0 and ignore writes: 10h[6:0], 33h[1:0], 34h[7:2], 44h[1:0], 47h[4:0], and every bit of 51h, 53h, 56h and 58h other than the one named above. Unmapped addresses read 0.
- R10: A read strobe loads rdata_o on the next clock with the value the register held before that clock. Without a read strobe, rdata_o holds.
- R11: Address 45h reads the err_cnt_i input. A write to 45h changes nothing, and in particular leaves the completion flag in place.
- R12: Identifier bytes 30h–33h, mask bytes 34h–38h, payload bytes 39h–40h, the 44h fields and threshold 46h store what is written (within their R9 masks). They appear on their outputs on the clock after the write, with the byte at base+k in bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| frm_done_i | input | 1 | Frame-received strobe from the matcher |
| frm_sync_i | input | 1 | Classic-frame decode in sync |
| frm_sync_fd_i | input | 1 | Flexible-data-rate decode in sync |
| ovf_set_i | input | 1 | Error counter overflow pulse |
| err_cnt_i | input | 8 | Current error counter value |
| wake_en_o | output | 1 | Wake enable |
| cfg_done_o | output | 1 | Configuration-complete flag |
| werr_o | output | 1 | Combined wake-error status |
| irq_o | output | 1 | Registered interrupt |
| fd_passive_o | output | 1 | Ignore flexible-data-rate frames in counting |
| rate_o | output | 3 | Nominal rate code |
| fd_ratio_o | output | 2 | Fast-phase rate ratio code |
| thresh_o | output | 8 | Error counter threshold |
| id_o | output | 32 | Identifier bytes 30h..33h |
| mask_o | output | 40 | Mask bytes 34h..38h |
| data_o | output | 8*N_DATA | Payload bytes from 39h |

## Verification
The bench builds the bank with ADDR_W=8 and N_DATA=8. With those values the payload region runs up to 40h, and the unmapped holes at 41h–43h sit inside the range that withdraws the completion flag. Writes there, and to 45h just outside the range, can therefore be told apart at the cfg_done_o port. The full 8-bit space also lets the bench read unmapped addresses below, between and above the mapped groups.

// File: rtl/swk_pkg.sv
package swk_pkg;
  // register addresses (the clearing range 30h..44h plus 46h depends on them)
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_ID0   = 8'h30;
  localparam logic [7:0] A_MSK0  = 8'h34;
  localparam logic [7:0] A_DAT0  = 8'h39;
  localparam logic [7:0] A_BUS   = 8'h44;
  localparam logic [7:0] A_ECNT  = 8'h45;
  localparam logic [7:0] A_THR   = 8'h46;
  localparam logic [7:0] A_STAT  = 8'h47;
  localparam logic [7:0] A_FLG   = 8'h51;
  localparam logic [7:0] A_ERR   = 8'h53;
  localparam logic [7:0] A_FLGIE = 8'h56;
  localparam logic [7:0] A_ERRIE = 8'h58;

  localparam logic [2:0] RATE_RST = 3'b101;
  localparam logic [7:0] THR_RST  = 8'h1F;

  typedef struct packed {
    logic       fd_passive;
    logic [2:0] rate;
    logic [1:0] fd_ratio;
    logic [7:0] thresh;
  } bus_cfg_t;

  function automatic logic rate_legal(input logic [2:0] code);
    return !(code == 3'b100 || code == 3'b110);
  endfunction
endpackage

// File: rtl/swk_filter_regs.sv
module swk_filter_regs
  import swk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_DATA = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [31:0]           id_o,
  output logic [39:0]           mask_o,
  output logic [8*N_DATA-1:0]   data_o,
  output logic [7:0]            rd_val_o
);
  localparam int N_ID  = 4;
  localparam int N_MSK = 5;
  localparam int DI_W  = (N_DATA > 1) ? $clog2(N_DATA) : 1;
  localparam logic [ADDR_W-1:0] ID_B = ADDR_W'(A_ID0);
  localparam logic [ADDR_W-1:0] MS_B = ADDR_W'(A_MSK0);
  localparam logic [ADDR_W-1:0] DT_B = ADDR_W'(A_DAT0);

  logic [ADDR_W-1:0] off_id, off_ms, off_dt;
  logic              hit_id, hit_ms, hit_dt;

  assign off_id = addr_i - ID_B;
  assign off_ms = addr_i - MS_B;
  assign off_dt = addr_i - DT_B;
  assign hit_id = (addr_i >= ID_B) && (off_id < ADDR_W'(N_ID));
  assign hit_ms = (addr_i >= MS_B) && (off_ms < ADDR_W'(N_MSK));
  assign hit_dt = (addr_i >= DT_B) && (off_dt < ADDR_W'(N_DATA));

  // identifier bytes: last byte has two reserved low bits
  for (genvar g = 0; g < N_ID; g++) begin : g_id
    localparam logic [7:0] KEEP = (g == N_ID - 1) ? 8'hFC : 8'hFF;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (we_i && hit_id && off_id == ADDR_W'(g))
        q <= wdata_i & KEEP;
    end
    assign id_o[8*g +: 8] = q;
  end

  // mask bytes: first byte only keeps its two low bits
  for (genvar g = 0; g < N_MSK; g++) begin : g_msk
    localparam logic [7:0] KEEP = (g == 0) ? 8'h03 : 8'hFF;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (we_i && hit_ms && off_ms == ADDR_W'(g))
        q <= wdata_i & KEEP;
    end
    assign mask_o[8*g +: 8] = q;
  end

  // payload bytes: one indexed array, single write port
  logic [7:0] dat_q [N_DATA];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_DATA; i++) dat_q[i] <= '0;
    end else if (we_i && hit_dt) begin
      dat_q[off_dt[DI_W-1:0]] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_DATA; g++) begin : g_dout
    assign data_o[8*g +: 8] = dat_q[g];
  end

  always_comb begin
    rd_val_o = '0;
    if (hit_id)
      rd_val_o = id_o[{off_id[1:0], 3'b000} +: 8];
    else if (hit_ms)
      rd_val_o = mask_o[{off_ms[2:0], 3'b000} +: 8];
    else if (hit_dt)
      rd_val_o = dat_q[off_dt[DI_W-1:0]];
  end
endmodule

// File: rtl/swk_ctl_regs.sv
module swk_ctl_regs
  import swk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              frm_done_i,
  input  logic              frm_sync_i,
  input  logic              frm_sync_fd_i,
  input  logic              ovf_set_i,
  input  logic [7:0]        err_cnt_i,
  output logic              wake_en_o,
  output logic              cfg_done_o,
  output logic              werr_o,
  output logic              irq_o,
  output bus_cfg_t          bus_o,
  output logic [7:0]        rd_val_o
);
  localparam logic [ADDR_W-1:0] AC    = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AB    = ADDR_W'(A_BUS);
  localparam logic [ADDR_W-1:0] AE    = ADDR_W'(A_ECNT);
  localparam logic [ADDR_W-1:0] AT    = ADDR_W'(A_THR);
  localparam logic [ADDR_W-1:0] AS    = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AF    = ADDR_W'(A_FLG);
  localparam logic [ADDR_W-1:0] AR    = ADDR_W'(A_ERR);
  localparam logic [ADDR_W-1:0] AFI   = ADDR_W'(A_FLGIE);
  localparam logic [ADDR_W-1:0] ARI   = ADDR_W'(A_ERRIE);
  localparam logic [ADDR_W-1:0] CLR_LO = ADDR_W'(A_ID0);

  logic     wake_en_q, cfg_done_q, sync_q, sync_fd_q;
  logic     ovf_q, ovf_ie_q, werr_ie_q, irq_q;
  bus_cfg_t bus_q;
  logic     werr;
  logic     cfg_wr;

  assign werr   = (wake_en_q && !cfg_done_q) || ovf_q;
  assign cfg_wr = we_i && (((addr_i >= CLR_LO) && (addr_i <= AB)) || addr_i == AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en_q  <= 1'b0;
      cfg_done_q <= 1'b0;
      bus_q      <= '{fd_passive: 1'b0, rate: RATE_RST, fd_ratio: 2'b00, thresh: THR_RST};
      sync_q     <= 1'b0;
      sync_fd_q  <= 1'b0;
      ovf_q      <= 1'b0;
      ovf_ie_q   <= 1'b1;
      werr_ie_q  <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      // enable may not rise while the error status stands
      if (we_i && addr_i == AC)
        wake_en_q <= wdata_i[7] && (wake_en_q || !werr);

      if (cfg_wr)
        cfg_done_q <= 1'b0;
      else if (we_i && addr_i == AS)
        cfg_done_q <= wdata_i[7];

      if (we_i && addr_i == AB) begin
        bus_q.fd_passive <= wdata_i[7];
        bus_q.fd_ratio   <= wdata_i[3:2];
        if (rate_legal(wdata_i[6:4]))
          bus_q.rate <= wdata_i[6:4];
      end
      if (we_i && addr_i == AT)
        bus_q.thresh <= wdata_i;

      if (frm_done_i) begin
        sync_q    <= frm_sync_i;
        sync_fd_q <= frm_sync_fd_i;
      end else if (rd_i && addr_i == AS) begin
        sync_q    <= 1'b0;
        sync_fd_q <= 1'b0;
      end

      if (ovf_set_i)
        ovf_q <= 1'b1;
      else if (we_i && addr_i == AF && wdata_i[3])
        ovf_q <= 1'b0;

      if (we_i && addr_i == AFI) ovf_ie_q  <= wdata_i[3];
      if (we_i && addr_i == ARI) werr_ie_q <= wdata_i[6];

      irq_q <= (ovf_q && ovf_ie_q) || (werr && werr_ie_q);
    end
  end

  always_comb begin
    unique case (addr_i)
      AC:      rd_val_o = {wake_en_q, 7'b0};
      AB:      rd_val_o = {bus_q.fd_passive, bus_q.rate, bus_q.fd_ratio, 2'b00};
      AE:      rd_val_o = err_cnt_i;
      AT:      rd_val_o = bus_q.thresh;
      AS:      rd_val_o = {cfg_done_q, sync_fd_q, sync_q, 5'b0};
      AF:      rd_val_o = {4'b0, ovf_q, 3'b0};
      AR:      rd_val_o = {1'b0, werr, 6'b0};
      AFI:     rd_val_o = {4'b0, ovf_ie_q, 3'b0};
      ARI:     rd_val_o = {1'b0, werr_ie_q, 6'b0};
      default: rd_val_o = 8'h00;
    endcase
  end

  assign wake_en_o  = wake_en_q;
  assign cfg_done_o = cfg_done_q;
  assign werr_o     = werr;
  assign irq_o      = irq_q;
  assign bus_o      = bus_q;
endmodule

// File: rtl/swk_regbank.sv
module swk_regbank
  import swk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_DATA = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic                frm_done_i,
  input  logic                frm_sync_i,
  input  logic                frm_sync_fd_i,
  input  logic                ovf_set_i,
  input  logic [7:0]          err_cnt_i,
  output logic                wake_en_o,
  output logic                cfg_done_o,
  output logic                werr_o,
  output logic                irq_o,
  output logic                fd_passive_o,
  output logic [2:0]          rate_o,
  output logic [1:0]          fd_ratio_o,
  output logic [7:0]          thresh_o,
  output logic [31:0]         id_o,
  output logic [39:0]         mask_o,
  output logic [8*N_DATA-1:0] data_o
);
  logic [7:0] rv_filt, rv_ctl, rdata_q;
  bus_cfg_t   bus;

  swk_filter_regs #(.ADDR_W(ADDR_W), .N_DATA(N_DATA)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .id_o     (id_o),
    .mask_o   (mask_o),
    .data_o   (data_o),
    .rd_val_o (rv_filt)
  );

  swk_ctl_regs #(.ADDR_W(ADDR_W)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .we_i          (we_i),
    .rd_i          (rd_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .frm_done_i    (frm_done_i),
    .frm_sync_i    (frm_sync_i),
    .frm_sync_fd_i (frm_sync_fd_i),
    .ovf_set_i     (ovf_set_i),
    .err_cnt_i     (err_cnt_i),
    .wake_en_o     (wake_en_o),
    .cfg_done_o    (cfg_done_o),
    .werr_o        (werr_o),
    .irq_o         (irq_o),
    .bus_o         (bus),
    .rd_val_o      (rv_ctl)
  );

  // address groups are disjoint, so an OR merges them
  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_i)
      rdata_q <= rv_filt | rv_ctl;
  end

  assign rdata_o      = rdata_q;
  assign fd_passive_o = bus.fd_passive;
  assign rate_o       = bus.rate;
  assign fd_ratio_o   = bus.fd_ratio;
  assign thresh_o     = bus.thresh;
endmodule

// File: rtl/swk_regbank_chk.sv
module swk_regbank_chk
  import swk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              we_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              ovf_set_i,
  input logic              wake_en_o,
  input logic              cfg_done_o,
  input logic              werr_o,
  input logic [2:0]        rate_o
);
  logic cfg_space_wr;
  assign cfg_space_wr = we_i && (((addr_i >= ADDR_W'(A_ID0)) && (addr_i <= ADDR_W'(A_BUS)))
                                 || addr_i == ADDR_W'(A_THR));

  // R2
  wake_block_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == ADDR_W'(A_CTRL) && !wake_en_o && werr_o) |=> !wake_en_o);

  // R3
  cfg_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_space_wr |=> !cfg_done_o);

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == ADDR_W'(A_STAT)) |=> (cfg_done_o == $past(wdata_i[7])));

  // R4
  werr_on_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_set_i |=> werr_o);

  // R7
  rate_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_o != 3'b100) && (rate_o != 3'b110));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

bind swk_regbank swk_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .we_i       (we_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ovf_set_i  (ovf_set_i),
  .wake_en_o  (wake_en_o),
  .cfg_done_o (cfg_done_o),
  .werr_o     (werr_o),
  .rate_o     (rate_o)
);

// File: tb/swk_regbank_test.sv
`timescale 1ns/1ps
module swk_regbank_test;
  localparam int AW = 8;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          we_i = 0, rd_i = 0, frm_done_i = 0, frm_sync_i = 0, frm_sync_fd_i = 0, ovf_set_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0, err_cnt_i = '0;
  logic [7:0]    rdata_o, thresh_o;
  logic          wake_en_o, cfg_done_o, werr_o, irq_o, fd_passive_o;
  logic [2:0]    rate_o;
  logic [1:0]    fd_ratio_o;
  logic [31:0]   id_o;
  logic [39:0]   mask_o;
  logic [8*ND-1:0] data_o;

  swk_regbank #(.ADDR_W(AW), .N_DATA(ND)) uut (
    .clk(clk), .rst(rst), .we_i(we_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .frm_done_i(frm_done_i), .frm_sync_i(frm_sync_i),
    .frm_sync_fd_i(frm_sync_fd_i), .ovf_set_i(ovf_set_i), .err_cnt_i(err_cnt_i),
    .wake_en_o(wake_en_o), .cfg_done_o(cfg_done_o), .werr_o(werr_o), .irq_o(irq_o),
    .fd_passive_o(fd_passive_o), .rate_o(rate_o), .fd_ratio_o(fd_ratio_o),
    .thresh_o(thresh_o), .id_o(id_o), .mask_o(mask_o), .data_o(data_o)
  );

  int total = 0, bad = 0;
  bit started = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_wen, m_cdone, m_fdp, m_sy, m_syfd, m_ovf, m_oie, m_eie, m_irq;
  bit [2:0] m_rate;
  bit [1:0] m_fdr;
  bit [7:0] m_thr, m_rdata;
  bit [7:0] m_id [4];
  bit [7:0] m_ms [5];
  bit [7:0] m_dt [ND];

  function automatic bit m_werr();
    return (m_wen && !m_cdone) || m_ovf;
  endfunction

  function automatic bit [7:0] m_read(input int a);
    if (a == 'h10) return {m_wen, 7'b0};
    if (a >= 'h30 && a <= 'h33) return m_id[a - 'h30];
    if (a >= 'h34 && a <= 'h38) return m_ms[a - 'h34];
    if (a >= 'h39 && a < 'h39 + ND) return m_dt[a - 'h39];
    if (a == 'h44) return {m_fdp, m_rate, m_fdr, 2'b00};
    if (a == 'h45) return err_cnt_i;
    if (a == 'h46) return m_thr;
    if (a == 'h47) return {m_cdone, m_syfd, m_sy, 5'b0};
    if (a == 'h51) return {4'b0, m_ovf, 3'b0};
    if (a == 'h53) return {1'b0, m_werr(), 6'b0};
    if (a == 'h56) return {4'b0, m_oie, 3'b0};
    if (a == 'h58) return {1'b0, m_eie, 6'b0};
    return 8'h00;
  endfunction

  always @(posedge clk) begin : model
    int a;
    bit w_old;
    bit [7:0] rv;
    started = 1;
    a = int'(addr_i);
    if (rst) begin
      m_wen = 0; m_cdone = 0; m_fdp = 0; m_sy = 0; m_syfd = 0; m_ovf = 0;
      m_oie = 1; m_eie = 0; m_irq = 0; m_rate = 3'b101; m_fdr = 0; m_thr = 8'h1F;
      m_rdata = 0;
      foreach (m_id[i]) m_id[i] = 0;
      foreach (m_ms[i]) m_ms[i] = 0;
      foreach (m_dt[i]) m_dt[i] = 0;
    end else begin
      w_old = m_werr();
      rv = m_read(a);
      m_irq = (m_ovf && m_oie) || (w_old && m_eie);
      if (rd_i) m_rdata = rv;
      if (frm_done_i) begin m_sy = frm_sync_i; m_syfd = frm_sync_fd_i; end
      else if (rd_i && a == 'h47) begin m_sy = 0; m_syfd = 0; end
      if (ovf_set_i) m_ovf = 1;
      else if (we_i && a == 'h51 && wdata_i[3]) m_ovf = 0;
      if (we_i) begin
        if (a == 'h10) m_wen = wdata_i[7] && (m_wen || !w_old);
        if (a >= 'h30 && a <= 'h33) m_id[a - 'h30] = (a == 'h33) ? (wdata_i & 8'hFC) : wdata_i;
        if (a >= 'h34 && a <= 'h38) m_ms[a - 'h34] = (a == 'h34) ? (wdata_i & 8'h03) : wdata_i;
        if (a >= 'h39 && a < 'h39 + ND) m_dt[a - 'h39] = wdata_i;
        if (a == 'h44) begin
          m_fdp = wdata_i[7]; m_fdr = wdata_i[3:2];
          if (wdata_i[6:4] != 3'b100 && wdata_i[6:4] != 3'b110) m_rate = wdata_i[6:4];
        end
        if (a == 'h46) m_thr = wdata_i;
        if (a == 'h47) m_cdone = wdata_i[7];
        if ((a >= 'h30 && a <= 'h44) || a == 'h46) m_cdone = 0;
        if (a == 'h56) m_oie = wdata_i[3];
        if (a == 'h58) m_eie = wdata_i[6];
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R2 wake_en", wake_en_o, m_wen);
      chk("R3 cfg_done", cfg_done_o, m_cdone);
      chk("R4 werr", werr_o, m_werr());
      chk("R6 irq", irq_o, m_irq);
      chk("R7 rate", rate_o, m_rate);
      chk("R10 rdata", rdata_o, m_rdata);
      chk("R12 bus fields", {fd_passive_o, fd_ratio_o, thresh_o}, {m_fdp, m_fdr, m_thr});
      chk("R12 id", id_o, {m_id[3], m_id[2], m_id[1], m_id[0]});
      chk("R12 mask", mask_o, {m_ms[4], m_ms[3], m_ms[2], m_ms[1], m_ms[0]});
      for (int i = 0; i < ND; i++) chk("R12 data", data_o[8*i +: 8], m_dt[i]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we_i = 1; rd_i = 0; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd_i = 1; we_i = 0; addr_i = a;
    @(negedge clk); rd_i = 0;
    chk(req, rdata_o, exp);
  endtask

  task automatic frame(input logic s, input logic sfd);
    @(negedge clk); frm_done_i = 1; frm_sync_i = s; frm_sync_fd_i = sfd;
    @(negedge clk); frm_done_i = 0;
  endtask

  task automatic ovf_pulse();
    @(negedge clk); ovf_set_i = 1;
    @(negedge clk); ovf_set_i = 0;
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle(3);
    @(negedge clk); rst = 0;
    // R1 reset values
    chk("R1 rate", rate_o, 3'b101);
    chk("R1 thresh", thresh_o, 8'h1F);
    chk("R1 irq", irq_o, 1'b0);
    rd_exp(8'h56, 8'h08, "R1 ovf ie");
    rd_exp(8'h58, 8'h00, "R1 err ie");
    rd_exp(8'h10, 8'h00, "R1 ctrl");

    // R12 / R9 filter storage and reserved bits
    wr(8'h30, 8'hA5); wr(8'h31, 8'h3C); wr(8'h32, 8'h7E); wr(8'h33, 8'hFF);
    wr(8'h34, 8'hFF); wr(8'h35, 8'h12); wr(8'h38, 8'hEB);
    for (int i = 0; i < ND; i++) wr(8'h39 + 8'(i), 8'(8'h11 * (i + 1)));
    rd_exp(8'h33, 8'hFC, "R9 id reserved");
    rd_exp(8'h34, 8'h03, "R9 mask reserved");
    rd_exp(8'h40, 8'h88, "R12 last data byte");
    rd_exp(8'h41, 8'h00, "R9 unmapped");
    rd_exp(8'h20, 8'h00, "R9 unmapped low");
    wr(8'h10, 8'h7F);
    rd_exp(8'h10, 8'h00, "R9 ctrl reserved");

    // R2/R3/R4 enable and completion
    wr(8'h10, 8'h80);
    chk("R2 set allowed", wake_en_o, 1'b1);
    chk("R4 werr en no cfg", werr_o, 1'b1);
    rd_exp(8'h53, 8'h40, "R4 read 53h");
    wr(8'h47, 8'h9F);
    chk("R3 cfg set", cfg_done_o, 1'b1);
    rd_exp(8'h47, 8'h80, "R9 stat reserved");
    err_cnt_i = 8'h5A;
    wr(8'h45, 8'h00);
    chk("R11 45h write keeps cfg", cfg_done_o, 1'b1);
    rd_exp(8'h45, 8'h5A, "R11 err count");
    wr(8'h42, 8'h00);
    chk("R3 hole clears cfg", cfg_done_o, 1'b0);
    wr(8'h47, 8'h80);
    wr(8'h46, 8'h40);
    chk("R3 thresh clears cfg", cfg_done_o, 1'b0);
    wr(8'h10, 8'h00);
    chk("R2 clear", wake_en_o, 1'b0);

    // R5 overflow, R2 blocking, R6 interrupt
    ovf_pulse();
    rd_exp(8'h51, 8'h08, "R5 flag set");
    wr(8'h10, 8'h80);
    chk("R2 set blocked", wake_en_o, 1'b0);
    idle(1);
    chk("R6 ovf irq", irq_o, 1'b1);
    wr(8'h56, 8'h00);
    idle(1);
    chk("R6 masked", irq_o, 1'b0);
    wr(8'h58, 8'h40);
    idle(1);
    chk("R6 werr irq", irq_o, 1'b1);
    @(negedge clk); we_i = 1; addr_i = 8'h51; wdata_i = 8'h08; ovf_set_i = 1;
    @(negedge clk); we_i = 0; ovf_set_i = 0;
    rd_exp(8'h51, 8'h08, "R5 set wins");
    wr(8'h51, 8'hF7);
    rd_exp(8'h51, 8'h08, "R5 write 0 ignored");
    wr(8'h51, 8'h08);
    rd_exp(8'h51, 8'h00, "R5 cleared");
    idle(2);
    chk("R6 irq low", irq_o, 1'b0);

    // R7 rate codes
    wr(8'h44, 8'hFF);
    chk("R7 rate 111", rate_o, 3'b111);
    wr(8'h44, 8'h47);
    chk("R7 rate 100 kept", rate_o, 3'b111);
    chk("R7 other fields", {fd_passive_o, fd_ratio_o}, 3'b001);
    wr(8'h44, 8'hE8);
    chk("R7 rate 110 kept", rate_o, 3'b111);
    rd_exp(8'h44, 8'hF8, "R9 bus reserved");
    wr(8'h44, 8'h30);
    chk("R7 rate 011", rate_o, 3'b011);

    // R8 sync flags
    frame(1'b1, 1'b1);
    rd_exp(8'h47, 8'h60, "R8 sync loaded");
    rd_exp(8'h47, 8'h00, "R8 cleared by read");
    frame(1'b1, 1'b0);
    @(negedge clk); rd_i = 1; addr_i = 8'h47; frm_done_i = 1; frm_sync_i = 0; frm_sync_fd_i = 1;
    @(negedge clk); rd_i = 0; frm_done_i = 0;
    chk("R8 read returns old", rdata_o, 8'h20);
    rd_exp(8'h47, 8'h40, "R8 frame beats clear");

    // R10 hold
    idle(3);
    chk("R10 hold", rdata_o, 8'h40);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule